// File: doc/BRIEF.md
# E1 Sa-Bit Transmit Data Link Inserter

This block sits in the transmit path of an E1 (PCM30) framer. It carries a serial data link in the national bit positions of timeslot 0. The upstream framer presents the outgoing stream one bit cell at a time, together with the cell's position in the frame and whether the frame is a non-frame-alignment frame. For each of the five national bits (Sa4 to Sa8), a 2-bit routing code chooses whether that bit comes from the data link pins. Where it does, the block gives an external data source a strobe for that cell, samples the serial data input, and puts the sampled bit into the stream in place of the upstream bit.

The block runs at twice the line rate (4.096 MHz), so each bit cell lasts two ticks. The strobe has two forms, chosen by a mode input. The first is a gapped clock that pulses for half a cell in each routed cell. The second is an active-low enable that stays low across the routed cells. Because Sa bits only exist in every other frame, the average rate of the gapped clock is 4 kb/s for each routed Sa bit. Frame alignment generation, CRC-4 and line coding take place elsewhere.

Top module: `e1_sa_dl_inserter`

## Requirements
- R1: Cell index 0 is bit 1 of timeslot 0. Sa(4+k) lies at cell index 3+k. That cell is routed when `nfas` is 1 and `sa_sel[2k+1:2k]` equals 01. Codes 00, 10 and 11 do not route the cell.
- R2: With `dl_mode`=0 (gapped clock), `dl_strb` is high for exactly the one tick after the first-half tick (`cell_half`=0) of each routed cell, and low at all other times.
- R3: With `dl_mode`=1 (active-low enable), `dl_strb` is low during the tick after every tick of a routed cell, and high otherwise. Adjacent routed cells therefore give one unbroken low period whose length follows the number of routed bits.
- R4: For a routed cell, `dl_in` is sampled at the edge that closes the cell's second half, which is where the gapped clock falls. The sampled value appears on `tx_bit`.
- R5: `tx_bit` changes only at edges where `cell_half` is 1, and it holds for the two ticks that follow.
- R6: For unrouted cells, including every cell of frames with `nfas`=0, `tx_bit` takes `up_bit` unchanged, and `dl_in` has no effect.
- R7: In clock mode, the number of strobe pulses in an NFAS frame equals the number of 01 codes, and a FAS frame has none. This gives 4 kb/s for each routed Sa bit.
- R8: While `rst_n` is low, `dl_strb` is 0 and `tx_bit` is 1.
- R9: A gapped-clock pulse only follows a cell from index 3 to 7 (the last five bit times of timeslot 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.096 MHz clock, two ticks per bit cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_idx | input | 8 | Bit cell index within the 256-bit frame |
| cell_half | input | 1 | 0 in the first tick of a cell, 1 in the second |
| nfas | input | 1 | 1 when the current frame does not carry the alignment signal |
| sa_sel | input | 10 | 2-bit routing code per Sa bit, Sa4 in bits 1:0 |
| dl_mode | input | 1 | 0 gapped clock, 1 active-low enable |
| up_bit | input | 1 | Upstream transmit bit for the current cell |
| dl_in | input | 1 | Serial data link input |
| dl_strb | output | 1 | Gapped clock or active-low enable toward the data source |
| tx_bit | output | 1 | Outgoing transmit bit after insertion |

## Verification
`dl_strb` reflects the inputs of a tick one clock later. `tx_bit` updates on the edge that ends a cell's second half and then holds for two ticks. The bench applies inputs at the falling edge and advances its behavioural model with those inputs. At the next falling edge it compares both outputs with the model's values, so each comparison lands exactly one registered stage after the stimulus. Pulse counts are totalled per frame and checked when the next frame begins. By then the last possible pulse, which follows cell 7, has long since arrived.

// File: rtl/e1dl_pkg.sv
package e1dl_pkg;
   typedef logic [1:0] sa_code_t;
   localparam sa_code_t SA_ROUTE_PINS = 2'b01;
   typedef enum logic {STRB_CLOCK = 1'b0, STRB_ENABLE = 1'b1} strb_mode_e;
endpackage

// File: rtl/e1dl_sa_decode.sv
module e1dl_sa_decode
   import e1dl_pkg::*;
#(
   parameter int NUM_SA     = 5,
   parameter int FIRST_CELL = 3,
   parameter int IDX_W      = 8
) (
   input  logic [IDX_W-1:0]    cell_idx,
   input  logic                nfas,
   input  logic [2*NUM_SA-1:0] sa_sel,
   output logic                hit
);
   logic [NUM_SA-1:0] hit_vec;

   // One comparator per national bit position (R1)
   for (genvar k = 0; k < NUM_SA; k++) begin : g_sa
      localparam logic [IDX_W-1:0] CELL = IDX_W'(FIRST_CELL + k);
      assign hit_vec[k] = nfas && (cell_idx == CELL) &&
                          (sa_code_t'(sa_sel[2*k +: 2]) == SA_ROUTE_PINS);
   end

   assign hit = |hit_vec;
endmodule

// File: rtl/e1dl_strobe_gen.sv
module e1dl_strobe_gen
   import e1dl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic cell_half,
   input  logic dl_mode,
   output logic dl_strb
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dl_strb <= 1'b0;
      end else if (strb_mode_e'(dl_mode) == STRB_CLOCK) begin
         dl_strb <= hit & ~cell_half;
      end else begin
         dl_strb <= ~hit;
      end
   end

   // A gapped-clock pulse lasts a single tick (half a bit cell)
   assert_pulse_half_cell_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dl_strb && !dl_mode) |=> (!dl_strb || dl_mode));
endmodule

// File: rtl/e1dl_insert.sv
module e1dl_insert (
   input  logic clk,
   input  logic rst_n,
   input  logic cell_half,
   input  logic hit,
   input  logic up_bit,
   input  logic dl_in,
   output logic tx_bit
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_bit <= 1'b1;
      end else if (cell_half) begin
         tx_bit <= hit ? dl_in : up_bit;
      end
   end

   assert_hold_first_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cell_half |=> $stable(tx_bit));
   assert_take_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_half && hit) |=> (tx_bit == $past(dl_in)));
   assert_pass_upstream_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_half && !hit) |=> (tx_bit == $past(up_bit)));
endmodule

// File: rtl/e1_sa_dl_inserter.sv
module e1_sa_dl_inserter #(
   parameter int NUM_SA          = 5,
   parameter int FIRST_CELL      = 3,
   parameter int CELLS_PER_FRAME = 256,
   parameter int TS_BITS         = 8,
   localparam int IDX_W          = $clog2(CELLS_PER_FRAME),
   localparam int SEL_W          = 2 * NUM_SA
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] cell_idx,
   input  logic             cell_half,
   input  logic             nfas,
   input  logic [SEL_W-1:0] sa_sel,
   input  logic             dl_mode,
   input  logic             up_bit,
   input  logic             dl_in,
   output logic             dl_strb,
   output logic             tx_bit
);
   // Elaboration-time parameter checks
   if (NUM_SA < 1) begin : g_chk_num
      $error("NUM_SA must be at least 1");
   end
   if (FIRST_CELL < 0 || FIRST_CELL + NUM_SA > TS_BITS) begin : g_chk_pos
      $error("national bits must lie inside timeslot 0");
   end
   if (CELLS_PER_FRAME < TS_BITS) begin : g_chk_frame
      $error("frame shorter than one timeslot");
   end

   logic hit;

   e1dl_sa_decode #(
      .NUM_SA     (NUM_SA),
      .FIRST_CELL (FIRST_CELL),
      .IDX_W      (IDX_W)
   ) u_decode (
      .cell_idx (cell_idx),
      .nfas     (nfas),
      .sa_sel   (sa_sel),
      .hit      (hit)
   );

   e1dl_strobe_gen u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .cell_half (cell_half),
      .dl_mode   (dl_mode),
      .dl_strb   (dl_strb)
   );

   e1dl_insert u_insert (
      .clk       (clk),
      .rst_n     (rst_n),
      .cell_half (cell_half),
      .hit       (hit),
      .up_bit    (up_bit),
      .dl_in     (dl_in),
      .tx_bit    (tx_bit)
   );

   // Clock pulses only follow a cell inside the national bit window
   assert_pulse_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dl_strb && !dl_mode && !$past(dl_mode)) |->
         (int'($past(cell_idx)) >= FIRST_CELL &&
          int'($past(cell_idx)) < FIRST_CELL + NUM_SA));
endmodule

// File: tb/e1_sa_dl_inserter_tb.sv
`timescale 1ns/1ps
module e1_sa_dl_inserter_tb;
   localparam int CLK_PERIOD = 244;
   localparam int TICKS_PER_FRAME = 512;
   localparam int FRAMES_PER_RUN = 4;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] cell_idx;
   logic       cell_half;
   logic       nfas;
   logic [9:0] sa_sel;
   logic       dl_mode;
   logic       up_bit;
   logic       dl_in;
   logic       dl_strb;
   logic       tx_bit;

   int errors = 0;
   int checks = 0;

   e1_sa_dl_inserter u_dut (
      .clk(clk), .rst_n(rst_n), .cell_idx(cell_idx), .cell_half(cell_half),
      .nfas(nfas), .sa_sel(sa_sel), .dl_mode(dl_mode), .up_bit(up_bit),
      .dl_in(dl_in), .dl_strb(dl_strb), .tx_bit(tx_bit)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   // Sa number n (4..8) is routed when its code is 01
   function automatic bit routed(logic [9:0] sel, int n);
      logic [1:0] code;
      code = sel[2*(n-4) +: 2];
      return code == 2'b01;
   endfunction

   function automatic int count_routed(logic [9:0] sel);
      int c = 0;
      for (int n = 4; n <= 8; n++) if (routed(sel, n)) c++;
      return c;
   endfunction

   // Reference: TS0 bit number is cell index plus one
   function automatic bit link_cell(int idx, bit nf, logic [9:0] sel);
      int bitno = idx + 1;
      if (!nf) return 1'b0;
      if (bitno < 4 || bitno > 8) return 1'b0;
      return routed(sel, bitno);
   endfunction

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      logic [9:0] cfgs [6];
      logic       exp_strb, exp_tx;
      string      strb_tag, tx_tag;
      int         pulses;

      cfgs[0] = 10'b01_01_01_01_01;  // all five routed
      cfgs[1] = 10'b00_00_00_00_01;  // Sa4 only
      cfgs[2] = 10'b01_00_00_00_00;  // Sa8 only
      cfgs[3] = 10'b00_01_00_01_00;  // Sa5 and Sa7
      cfgs[4] = 10'b11_10_01_11_10;  // Sa6 routed, others other codes
      cfgs[5] = 10'b00_00_00_00_00;  // nothing routed

      rst_n = 1'b0; cell_idx = '0; cell_half = 1'b0; nfas = 1'b0;
      sa_sel = cfgs[0]; dl_mode = 1'b0; up_bit = 1'b0; dl_in = 1'b1;
      repeat (3) @(negedge clk);
      check("R8", "reset dl_strb", dl_strb, 1'b0);
      check("R8", "reset tx_bit", tx_bit, 1'b1);
      rst_n = 1'b1;
      exp_strb = 1'b0; exp_tx = 1'b1;
      strb_tag = "R2"; tx_tag = "R5";
      pulses = 0;

      for (int m = 0; m < 2; m++) begin
         for (int c = 0; c < 6; c++) begin
            for (int t = 0; t < TICKS_PER_FRAME * FRAMES_PER_RUN; t++) begin
               bit s;
               @(negedge clk);
               check(strb_tag, "dl_strb", dl_strb, exp_strb);
               check(tx_tag, "tx_bit", tx_bit, exp_tx);
               if (dl_mode == 1'b0 && dl_strb === 1'b1) pulses++;
               if (t % TICKS_PER_FRAME == 0) begin
                  if (t > 0 && dl_mode == 1'b0)
                     check("R7", "pulses per frame", 1'(pulses == (nfas ? count_routed(sa_sel) : 0)), 1'b1);
                  pulses = 0;
               end
               // apply next tick
               dl_mode   = 1'(m);
               sa_sel    = cfgs[c];
               cell_idx  = 8'((t / 2) % 256);
               cell_half = 1'(t % 2);
               nfas      = 1'((t / TICKS_PER_FRAME) % 2);
               up_bit    = 1'($urandom);
               dl_in     = 1'($urandom);
               s = link_cell(int'(cell_idx), nfas, sa_sel);
               exp_strb = dl_mode ? !s : (s && !cell_half);
               if (s) strb_tag = dl_mode ? "R1 R3" : "R1 R2";
               else if (cell_idx >= 3 && cell_idx <= 7) strb_tag = dl_mode ? "R3" : "R2";
               else strb_tag = dl_mode ? "R3" : "R9";
               if (cell_half) begin
                  exp_tx = s ? dl_in : up_bit;
                  tx_tag = s ? "R4" : "R6";
               end else begin
                  tx_tag = "R5";
               end
            end
         end
      end
      @(negedge clk);
      check(strb_tag, "dl_strb", dl_strb, exp_strb);
      check(tx_tag, "tx_bit", tx_bit, exp_tx);
      summary();
      $finish;
   end
endmodule